// File: doc/BRIEF.md
# Bus-Fronted Word Queue

This block is a bus slave for a simple handshake bus with no pipelining. The bus offers a cycle strobe, a request strobe, a write-enable and a data word each way. Behind the slave sits a first-in-first-out word queue. A write request stores its data word at the tail of the queue. A read request removes the oldest word and hands it back to the bus master. The bus has no address. A request is any cycle in which the cycle and request strobes are both high.

Inside, the bus side talks to the queue over two valid/ready stream links. On the enqueue link the bridge supplies valid and data and the queue supplies ready. On the dequeue link the queue supplies valid and data and the bridge supplies ready. A word moves on either link only in a cycle where its valid and ready are both high. Acknowledge is held back until such a transfer has taken place. A full queue therefore stalls writes, and an empty queue stalls reads. Reset is synchronous and active high.

Top module: `wbQueueBridge`

## Requirements
- R1: Words written by write requests come out of later read requests in the order they were written, across any interleaving of reads and writes.
- R2: A read request removes exactly the oldest stored word. That word is present on `wbDatR` in the cycle where `wbAck` is high.
- R3: When the queue can take or give a word, `wbAck` rises in the clock cycle after the request is first presented. `wbAck` is high for one cycle only for each request.
- R4: `wbAck` is low in every cycle where `wbCyc` or `wbStb` is low, even when the queue holds data.
- R5: A write request while the queue holds DEPTH words gets no acknowledge. If the master withdraws it, nothing is stored, and the queue keeps its earlier words in order.
- R6: A read request while the queue is empty gets no acknowledge. If the master withdraws it, later writes and reads behave as if the read had never been issued.
- R7: No word is moved in the cycle where `wbAck` is high. A master that keeps its strobes high through the acknowledge starts exactly one new transfer in the next cycle.
- R8: Synchronous reset (`rst` high) empties the queue and holds `wbAck` low. A read right after reset stalls.
- R9: `wbDatR` keeps the last word read until the next read transfer. Write requests do not change it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wbCyc | input | 1 | Bus cycle in progress |
| wbStb | input | 1 | Request strobe |
| wbWe | input | 1 | 1 = write request, 0 = read request |
| wbDatW | input | DATA_W | Write data from master |
| wbDatR | output | DATA_W | Read data to master, held between reads |
| wbAck | output | 1 | Request acknowledge, one-cycle pulse |

## Verification
A wrong queue pointer or count shows up first as a wrong word on `wbDatR` in the acknowledge cycle of a read. It can also show up as a stall that comes one word too early or too late at the full or empty edge. A software queue model catches both on the first read that follows. A stuck acknowledge register shows up within one cycle of the acknowledge, as a pulse longer than one cycle or as a second word moved during a held strobe. Wrong gating of the acknowledge shows up as `wbAck` high while the strobes are low.

// File: rtl/wbqPkg.sv
package wbqPkg;
  // Strobes from the control to the datapath and queue
  typedef struct packed {
    logic pushReq;   // enqueue link valid
    logic popReq;    // dequeue link ready
    logic capRead;   // latch the dequeued word into the read register
  } wbqStrobe_t;
endpackage

// File: rtl/wbqFifo.sv
module wbqFifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [W-1:0] inData,
  output logic         inReady,
  output logic         outValid,
  output logic [W-1:0] outData,
  input  logic         outReady
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          push, pop;

  assign inReady  = (count != CW'(DEPTH));
  assign outValid = (count != '0);
  assign outData  = mem[rdPtr];
  assign push     = inValid & inReady;
  assign pop      = outValid & outReady;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= inData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/wbqCtl.sv
module wbqCtl
  import wbqPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wbCyc,
  input  logic       wbStb,
  input  logic       wbWe,
  input  logic       enqReady,
  input  logic       deqValid,
  output wbqStrobe_t strb,
  output logic       wbAck
);
  logic ackReg;
  logic pending;
  logic xferDone;

  // A request counts only until it has been acknowledged
  assign pending      = wbCyc & wbStb & ~ackReg;
  assign strb.pushReq = pending & wbWe;
  assign strb.popReq  = pending & ~wbWe;
  assign strb.capRead = strb.popReq & deqValid;
  assign xferDone     = (strb.pushReq & enqReady) | strb.capRead;

  always_ff @(posedge clk) begin
    if (rst) ackReg <= 1'b0;
    else     ackReg <= xferDone;
  end

  assign wbAck = ackReg & wbCyc & wbStb;
endmodule

// File: rtl/wbqDp.sv
module wbqDp
  import wbqPkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  wbqStrobe_t   strb,
  input  logic [W-1:0] wbDatW,
  input  logic [W-1:0] deqData,
  output logic [W-1:0] enqData,
  output logic [W-1:0] wbDatR
);
  logic [W-1:0] rdReg;

  assign enqData = wbDatW;

  always_ff @(posedge clk) begin
    if (rst)               rdReg <= '0;
    else if (strb.capRead) rdReg <= deqData;
  end

  assign wbDatR = rdReg;
endmodule

// File: rtl/wbQueueBridge.sv
module wbQueueBridge
  import wbqPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wbCyc,
  input  logic              wbStb,
  input  logic              wbWe,
  input  logic [DATA_W-1:0] wbDatW,
  output logic [DATA_W-1:0] wbDatR,
  output logic              wbAck
);
  wbqStrobe_t        strb;
  logic              enqValid, enqReady;
  logic              deqValid, deqReady;
  logic [DATA_W-1:0] enqData, deqData;

  assign enqValid = strb.pushReq;
  assign deqReady = strb.popReq;

  wbqCtl uCtl (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .enqReady(enqReady), .deqValid(deqValid), .strb(strb), .wbAck(wbAck)
  );

  wbqDp #(.W(DATA_W)) uDp (
    .clk(clk), .rst(rst), .strb(strb), .wbDatW(wbDatW),
    .deqData(deqData), .enqData(enqData), .wbDatR(wbDatR)
  );

  wbqFifo #(.W(DATA_W), .DEPTH(DEPTH)) uFifo (
    .clk(clk), .rst(rst),
    .inValid(enqValid), .inData(enqData), .inReady(enqReady),
    .outValid(deqValid), .outData(deqData), .outReady(deqReady)
  );
endmodule

// File: rtl/wbQueueBridgeChk.sv
module wbQueueBridgeChk (
  input logic clk,
  input logic rst,
  input logic wbCyc,
  input logic wbStb,
  input logic wbWe,
  input logic wbAck,
  input logic enqValid,
  input logic enqReady,
  input logic deqValid,
  input logic deqReady
);
  a_r3_ack_single: assert property (@(posedge clk) disable iff (rst)
    wbAck |=> !wbAck);

  a_r3_ack_after_xfer: assert property (@(posedge clk) disable iff (rst)
    wbAck |-> $past((enqValid && enqReady) || (deqValid && deqReady)));

  a_r4_ack_needs_strobes: assert property (@(posedge clk) disable iff (rst)
    !(wbCyc && wbStb) |-> !wbAck);

  a_r5_full_write_stalls: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && wbWe && !wbAck && !enqReady) |=> !wbAck);

  a_r6_empty_read_stalls: assert property (@(posedge clk) disable iff (rst)
    (wbCyc && wbStb && !wbWe && !wbAck && !deqValid) |=> !wbAck);

  a_r7_no_move_in_ack: assert property (@(posedge clk) disable iff (rst)
    wbAck |-> (!enqValid && !deqReady));

  a_r8_reset_clears: assert property (@(posedge clk)
    $past(rst) |-> (!wbAck && !deqValid));
endmodule

bind wbQueueBridge wbQueueBridgeChk uChk (
  .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
  .wbAck(wbAck), .enqValid(enqValid), .enqReady(enqReady),
  .deqValid(deqValid), .deqReady(deqReady)
);

// File: tb/tb_wbQueueBridge.sv
module tb_wbQueueBridge;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 4;
  localparam int NVEC   = 16;
  // bit 32 = write request, bits 31:0 = write data
  localparam logic [32:0] VEC [NVEC] = '{
    33'h1_0000_0011, 33'h1_0000_0022, 33'h0_0000_0000, 33'h1_0000_0033,
    33'h0_0000_0000, 33'h0_0000_0000, 33'h1_0000_0044, 33'h1_0000_0055,
    33'h1_0000_0066, 33'h0_0000_0000, 33'h1_0000_0077, 33'h0_0000_0000,
    33'h0_0000_0000, 33'h0_0000_0000, 33'h1_0000_0088, 33'h0_0000_0000
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wbCyc = 1'b0, wbStb = 1'b0, wbWe = 1'b0;
  logic [DATA_W-1:0] wbDatW = '0;
  logic [DATA_W-1:0] wbDatR;
  logic wbAck;

  int total = 0;
  int failed = 0;
  logic [DATA_W-1:0] model [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  wbQueueBridge #(.DATA_W(DATA_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe),
    .wbDatW(wbDatW), .wbDatR(wbDatR), .wbAck(wbAck)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic isW, input logic [31:0] d, input int limit,
                      output logic acked, output int lat, output logic [31:0] rd);
    @(negedge clk);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = isW; wbDatW = d;
    acked = 1'b0; lat = 0; rd = '0;
    while (!acked && lat < limit) begin
      @(negedge clk);
      lat++;
      if (wbAck) begin acked = 1'b1; rd = wbDatR; end
    end
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
  endtask

  task automatic doWrite(input logic [31:0] d, input string req);
    logic a; int l; logic [31:0] r;
    xfer(1'b1, d, 8, a, l, r);
    check(a && l == 1, req, 32'(l), 32'd1);
    if (a) model.push_back(d);
  endtask

  task automatic doRead(input string req);
    logic a; int l; logic [31:0] r; logic [31:0] e;
    e = model.pop_front();
    xfer(1'b0, 32'h0, 8, a, l, r);
    check(a && l == 1, {req, " latency"}, 32'(l), 32'd1);
    check(r == e, {req, " data"}, r, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic a; int l; logic [31:0] r;
    repeat (3) @(negedge clk);
    check(wbAck == 1'b0, "R8 ack low in reset", 32'(wbAck), 0);
    rst = 1'b0;
    // R8: read right after reset stalls
    xfer(1'b0, 0, 5, a, l, r);
    check(!a, "R8 read after reset stalls", 32'(a), 0);

    // R1/R2/R3: table walk against the software queue model
    for (int i = 0; i < NVEC; i++) begin
      if (VEC[i][32]) doWrite(VEC[i][31:0], "R1 R3 table write");
      else            doRead("R1 R2 table read");
    end

    // R9: a write leaves the read register untouched (last read was 0x88)
    doWrite(32'h0000_00AA, "R9 write");
    @(negedge clk);
    check(wbDatR == 32'h88, "R9 read data held over write", wbDatR, 32'h88);

    // R4: data present but strobes low, ack stays low
    wbCyc = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(!wbAck, "R4 cyc only no ack", 32'(wbAck), 0);
    end
    wbCyc = 1'b0;
    doRead("R2 read after idle");

    // R5: fill, then a write to the full queue stalls and is not stored
    for (int k = 0; k < DEPTH; k++) doWrite(32'h100 + 32'(k), "R5 fill");
    xfer(1'b1, 32'hDEAD, 10, a, l, r);
    check(!a, "R5 write to full stalls", 32'(a), 0);
    for (int k = 0; k < DEPTH; k++) doRead("R5 drain order");

    // R6: read of empty queue stalls and leaves no trace
    xfer(1'b0, 0, 10, a, l, r);
    check(!a, "R6 read of empty stalls", 32'(a), 0);
    doWrite(32'h0000_0BEE, "R6 write after stall");
    doRead("R6 read after stall");

    // R7/R3: strobes held through the acknowledge
    @(negedge clk);
    wbCyc = 1'b1; wbStb = 1'b1; wbWe = 1'b1; wbDatW = 32'hA1;
    @(negedge clk);
    check(wbAck, "R3 first held write acked", 32'(wbAck), 1);
    wbDatW = 32'hB2;
    @(negedge clk);
    check(!wbAck, "R3 ack is one cycle", 32'(wbAck), 0);
    @(negedge clk);
    check(wbAck, "R7 second held write acked", 32'(wbAck), 1);
    wbCyc = 1'b0; wbStb = 1'b0; wbWe = 1'b0;
    model.push_back(32'hA1);
    model.push_back(32'hB2);
    doRead("R7 first word");
    doRead("R7 second word");
    xfer(1'b0, 0, 6, a, l, r);
    check(!a, "R7 exactly two words stored", 32'(a), 0);

    // R8: reset in the middle empties the queue
    doWrite(32'h55, "R8 pre-reset write");
    doWrite(32'h66, "R8 pre-reset write");
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    check(!wbAck, "R8 ack low in reset", 32'(wbAck), 0);
    rst = 1'b0;
    model.delete();
    xfer(1'b0, 0, 6, a, l, r);
    check(!a, "R8 queue empty after reset", 32'(a), 0);
    doWrite(32'h77, "R8 write after reset");
    doRead("R8 read after reset");

    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule